// File: doc/BRIEF.md
# Descriptor-Driven DMA Cycle Controller

This block is a single-channel DMA engine. It runs its transfers from two descriptors held in registers, a primary and an alternate. Each descriptor stores the last source address, the last destination address and a control word. The control word gives the cycle type, the element count minus one, the element size, the source and destination increment codes and a burst exponent. Software fills the descriptors through a small configuration port, picks the starting descriptor, enables the channel and, for memory-to-memory copies, strobes a software request. Peripheral-paced cycles advance on a request line instead.

Every element takes one read cycle and one write cycle on a simple memory port. The element address is derived from the stored end pointer and the live remaining count, and that count is decremented inside the descriptor itself. When a descriptor finishes, the controller marks it invalid. In a ping-pong run it then hands over to the other descriptor, or halts. A basic descriptor is the last one of such a run. Software reloads the idle descriptor while the other one is working.

Top module: `dma_cycle_ctrl`

## Requirements
- R1: After reset, chan_en, done, alt_active, mem_re and mem_we are all 0.
- R2: For element i of a descriptor moving N elements, the read and write addresses are end - ((N-1-i) << code). Increment code 0, 1 or 2 gives a stride of 1, 2 or 4 bytes, and code 3 keeps the address fixed at the end pointer. mem_wsize carries the size code: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes. The data read is written unchanged.
- R3: An auto-request descriptor starts on one sw_req pulse while enabled and moves all N elements without further requests, whatever its burst exponent. per_req has no effect on it.
- R4: A basic or ping-pong descriptor moves at most 2^R elements per per_req seen while idle, then waits for the next request. An exponent above the count width means the whole descriptor.
- R5: When a basic or auto-request descriptor completes, chan_en falls and done is high for exactly one cycle.
- R6: While a descriptor runs, its count field holds the remaining elements minus one. On completion its cycle type and count are written back as 0, and all other control bits are kept.
- R7: alt_clr selects the primary and alt_set selects the alternate. These act only while idle, and alt_active shows which descriptor is in use.
- R8: When a ping-pong descriptor completes and the other descriptor is valid, alt_active toggles, done pulses and chan_en stays 1.
- R9: When a ping-pong descriptor completes and the other descriptor has cycle type 0, done pulses, alt_active toggles and chan_en falls.
- R10: A basic descriptor reached through a ping-pong hand-over ends the run: after it completes, chan_en is 0.
- R11: If the channel is enabled while the active descriptor has cycle type 0, chan_en falls on the next clock edge and no transfer happens.
- R12: Configuration port: cfg_field 0 selects the source end, 1 the destination end and 2 the control word, and cfg_alt picks the alternate. The control word holds the cycle type in [1:0] (0 invalid, 1 basic, 2 auto-request, 3 ping-pong), N-1 in [11:2], the size code in [13:12], the source increment in [15:14], the destination increment in [17:16] and R in [21:18]. cfg_rdata returns the selected register.
- R13: A count field of 1023 moves 1024 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor register write strobe |
| cfg_alt | input | 1 | Descriptor select for cfg access (1 = alternate) |
| cfg_field | input | 2 | Register select: source end, destination end, control |
| cfg_wdata | input | 32 | Descriptor write data |
| cfg_rdata | output | 32 | Selected descriptor register |
| en_set | input | 1 | Enable the channel (idle only) |
| en_clr | input | 1 | Disable the channel (idle only) |
| alt_set | input | 1 | Select alternate descriptor (idle only) |
| alt_clr | input | 1 | Select primary descriptor (idle only) |
| per_req | input | 1 | Peripheral request |
| sw_req | input | 1 | Software request strobe |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | 32 | Memory read byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Write data, low bytes used |
| mem_wsize | output | 2 | Write size code |
| done | output | 1 | One-cycle completion pulse |
| chan_en | output | 1 | Channel enabled |
| alt_active | output | 1 | Descriptor in use (1 = alternate) |

## Verification
A table of auto-request copies covers all three element sizes, matched strides, a fixed source, a 4-byte-stride gather into bytes and a single-element descriptor. Each one pins down a different term of the end-minus-scaled-count address rule. A copy with fixed pointers and the full 1024-element count shows that the count field is read at its maximum. Basic runs with a small exponent are compared with auto runs that use the same exponent, which separates peripheral pacing from software-started completion. Three ping-pong setups exercise the three exits from a completed descriptor: the partner is valid, the partner is invalid, and the partner is basic.

// File: rtl/dma_cycle_ctrl.sv
module dma_cycle_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 10,
  parameter int RP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_alt,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              alt_set,
  input  logic              alt_clr,
  input  logic              per_req,
  input  logic              sw_req,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        mem_wsize,
  output logic              done,
  output logic              chan_en,
  output logic              alt_active
);
  localparam int N_LO  = 2;
  localparam int SZ_LO = N_LO + CNT_W;
  localparam int SI_LO = SZ_LO + 2;
  localparam int DI_LO = SI_LO + 2;
  localparam int RP_LO = DI_LO + 2;
  localparam logic [1:0] CY_NONE = 2'd0, CY_BASIC = 2'd1, CY_AUTO = 2'd2, CY_PING = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_t;

  logic [ADDR_W-1:0] src_end [2];
  logic [ADDR_W-1:0] dst_end [2];
  logic [ADDR_W-1:0] ctrl    [2];
  st_t               state;
  logic              en_q, alt_q, done_q, auto_run;
  logic [CNT_W:0]    bcnt;

  logic [1:0]       cyc, sz, si, di, oth_cyc;
  logic [CNT_W-1:0] n;
  logic [RP_W-1:0]  rp;
  logic [CNT_W:0]   bmax;
  logic             start_p, start_a, start, bad, last;

  function automatic logic [ADDR_W-1:0] elem_addr(input logic [ADDR_W-1:0] e,
                                                  input logic [CNT_W-1:0] k,
                                                  input logic [1:0] inc);
    if (inc == 2'd3) return e;
    return e - (ADDR_W'(k) << inc);
  endfunction

  assign cyc     = ctrl[alt_q][1:0];
  assign n       = ctrl[alt_q][N_LO +: CNT_W];
  assign sz      = ctrl[alt_q][SZ_LO +: 2];
  assign si      = ctrl[alt_q][SI_LO +: 2];
  assign di      = ctrl[alt_q][DI_LO +: 2];
  assign rp      = ctrl[alt_q][RP_LO +: RP_W];
  assign oth_cyc = ctrl[~alt_q][1:0];
  assign bmax    = (int'(rp) > CNT_W) ? '1 : (CNT_W+1)'((1 << rp) - 1);
  assign last    = (n == '0);

  assign start_p = en_q && per_req && (cyc == CY_BASIC || cyc == CY_PING);
  assign start_a = en_q && sw_req && (cyc == CY_AUTO);
  assign start   = start_p || start_a;
  assign bad     = en_q && (cyc == CY_NONE);

  assign mem_re     = (state == ST_RD);
  assign mem_we     = (state == ST_WR);
  assign mem_raddr  = elem_addr(src_end[alt_q], n, si);
  assign mem_waddr  = elem_addr(dst_end[alt_q], n, di);
  assign mem_wdata  = mem_rdata;
  assign mem_wsize  = sz;
  assign done       = done_q;
  assign chan_en    = en_q;
  assign alt_active = alt_q;

  always_comb begin
    case (cfg_field)
      2'd0:    cfg_rdata = src_end[cfg_alt];
      2'd1:    cfg_rdata = dst_end[cfg_alt];
      2'd2:    cfg_rdata = ctrl[cfg_alt];
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        src_end[i] <= '0;
        dst_end[i] <= '0;
        ctrl[i]    <= '0;
      end
      state    <= ST_IDLE;
      en_q     <= 1'b0;
      alt_q    <= 1'b0;
      done_q   <= 1'b0;
      auto_run <= 1'b0;
      bcnt     <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we) begin
        case (cfg_field)
          2'd0:    src_end[cfg_alt] <= cfg_wdata;
          2'd1:    dst_end[cfg_alt] <= cfg_wdata;
          2'd2:    ctrl[cfg_alt]    <= cfg_wdata;
          default: ;
        endcase
      end
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RD;
            bcnt     <= '0;
            auto_run <= start_a;
          end else begin
            if (en_clr)      en_q <= 1'b0;
            else if (en_set) en_q <= 1'b1;
            else if (bad)    en_q <= 1'b0;
            if (alt_clr)      alt_q <= 1'b0;
            else if (alt_set) alt_q <= 1'b1;
          end
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          if (last) begin
            ctrl[alt_q][1:0] <= CY_NONE;
            done_q   <= 1'b1;
            auto_run <= 1'b0;
            state    <= ST_IDLE;
            if (cyc == CY_PING) begin
              alt_q <= ~alt_q;
              if (oth_cyc == CY_NONE) en_q <= 1'b0;
            end else begin
              en_q <= 1'b0;
            end
          end else begin
            ctrl[alt_q][N_LO +: CNT_W] <= n - CNT_W'(1);
            bcnt <= bcnt + (CNT_W+1)'(1);
            if (auto_run || bcnt != bmax) state <= ST_RD;
            else                          state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_cycle_ctrl_chk.sv
module dma_cycle_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_re,
  input logic mem_we,
  input logic done,
  input logic chan_en,
  input logic alt_active,
  input logic alt_set,
  input logic alt_clr
);
  assert_rw_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_write_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> chan_en);

  assert_handover_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(alt_active) && !$past(alt_set) && !$past(alt_clr)) |-> done);
endmodule

bind dma_cycle_ctrl dma_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we), .done(done),
  .chan_en(chan_en), .alt_active(alt_active), .alt_set(alt_set), .alt_clr(alt_clr)
);

// File: tb/sim_dma_cycle_ctrl.sv
module sim_dma_cycle_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_alt = 0;
  logic [1:0] cfg_field = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic en_set = 0, en_clr = 0, alt_set = 0, alt_clr = 0, per_req = 0, sw_req = 0;
  logic mem_re, mem_we, done, chan_en, alt_active;
  logic [31:0] mem_raddr, mem_waddr, mem_wdata, mem_rdata;
  logic [1:0] mem_wsize;

  int checks = 0, errors = 0, wr_cnt = 0, done_cnt = 0;
  logic tb_fill = 0;
  logic [7:0] mem [0:255];

  always #10 clk = ~clk;

  dma_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_alt(cfg_alt), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .en_set(en_set), .en_clr(en_clr),
    .alt_set(alt_set), .alt_clr(alt_clr), .per_req(per_req), .sw_req(sw_req),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wsize(mem_wsize),
    .done(done), .chan_en(chan_en), .alt_active(alt_active)
  );

  function automatic logic [7:0] pat(input int a);
    return (a < 128) ? 8'(a * 37 + 11) : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (tb_fill) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (mem_we) begin
      for (int b = 0; b < (1 << mem_wsize); b++)
        mem[8'(mem_waddr + 32'(b))] <= mem_wdata[8*b +: 8];
    end
    if (mem_re)
      mem_rdata <= {mem[8'(mem_raddr + 3)], mem[8'(mem_raddr + 2)],
                    mem[8'(mem_raddr + 1)], mem[8'(mem_raddr)]};
  end

  always @(negedge clk) begin
    if (mem_we) wr_cnt++;
    if (done) done_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic alt, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_alt = alt; cfg_field = f; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic alt, input logic [1:0] f, output logic [31:0] d);
    @(negedge clk); cfg_alt = alt; cfg_field = f; #1 d = cfg_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: en_set = 1; 1: en_clr = 1; 2: alt_set = 1; 3: alt_clr = 1;
      4: per_req = 1; default: sw_req = 1;
    endcase
    @(negedge clk);
    en_set = 0; en_clr = 0; alt_set = 0; alt_clr = 0; per_req = 0; sw_req = 0;
  endtask

  task automatic fill();
    @(negedge clk); tb_fill = 1; @(negedge clk); tb_fill = 0;
  endtask

  task automatic wait_done(input int limit);
    int start = done_cnt;
    for (int k = 0; k < limit && done_cnt == start; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [1:0] cy, input logic [9:0] nm,
      input logic [1:0] sz, input logic [1:0] si, input logic [1:0] di, input logic [3:0] rp);
    return {10'd0, rp, di, si, sz, nm, cy};
  endfunction

  function automatic logic [31:0] end_of(input logic [31:0] s, input logic [9:0] nm,
                                         input logic [1:0] inc);
    return (inc == 2'd3) ? s : s + (32'(nm) << inc);
  endfunction

  task automatic load(input logic alt, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] c);
    cfg_wr(alt, 2'd0, end_of(s, c[11:2], c[15:14]));
    cfg_wr(alt, 2'd1, end_of(d, c[11:2], c[17:16]));
    cfg_wr(alt, 2'd2, c);
  endtask

  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 10'd7},
    {2'd1, 2'd1, 2'd1, 10'd4},
    {2'd2, 2'd2, 2'd2, 10'd3},
    {2'd0, 2'd3, 2'd0, 10'd5},
    {2'd2, 2'd2, 2'd2, 10'd0},
    {2'd0, 2'd2, 2'd0, 10'd6}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] c, rd;
    int bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 chan_en", 32'(chan_en), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 alt_active", 32'(alt_active), 0);
    chk("R1 mem_re|mem_we", 32'(mem_re | mem_we), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R5 R6 R12: auto-request copies from the vector table
    for (int v = 0; v < NV; v++) begin
      fill();
      c = mk_ctrl(2'd2, VEC[v][9:0], VEC[v][15:14], VEC[v][13:12], VEC[v][11:10], 4'd1);
      load(1'b0, 32'h10, 32'h80, c);
      cfg_rd(1'b0, 2'd2, rd);
      chk("R12 ctrl readback", rd, c);
      pulse(3); pulse(0);
      wr_cnt = 0;
      pulse(5);
      wait_done(60);
      @(negedge clk);
      chk("R3 auto element count", 32'(wr_cnt), 32'(VEC[v][9:0]) + 1);
      chk("R5 chan_en after auto", 32'(chan_en), 0);
      bad = 0;
      for (int e = 0; e <= int'(VEC[v][9:0]); e++)
        for (int b = 0; b < (1 << VEC[v][15:14]); b++) begin
          int d = 'h80 + ((VEC[v][11:10] == 3) ? 0 : (e << VEC[v][11:10])) + b;
          int s = 'h10 + ((VEC[v][13:12] == 3) ? 0 : (e << VEC[v][13:12])) + b;
          if (mem[d & 255] !== pat(s)) bad++;
        end
      chk("R2 copied bytes mismatches", 32'(bad), 0);
      cfg_rd(1'b0, 2'd2, rd);
      chk("R6 write-back ctrl", rd, c & ~32'hFFF);
    end

    // R4 R6 R5: basic, burst of 2 per request, 5 elements
    fill();
    c = mk_ctrl(2'd1, 10'd4, 2'd0, 2'd0, 2'd0, 4'd1);
    load(1'b0, 32'h10, 32'h80, c);
    pulse(3); pulse(0);
    wr_cnt = 0; done_cnt = 0;
    pulse(4); repeat (8) @(negedge clk);
    chk("R4 first burst writes", 32'(wr_cnt), 2);
    chk("R4 still enabled", 32'(chan_en), 1);
    cfg_rd(1'b0, 2'd2, rd);
    chk("R6 remaining count field", 32'(rd[11:2]), 2);
    pulse(4); repeat (8) @(negedge clk);
    chk("R4 second burst writes", 32'(wr_cnt), 4);
    pulse(4); repeat (8) @(negedge clk);
    chk("R4 final writes", 32'(wr_cnt), 5);
    chk("R5 one done pulse", 32'(done_cnt), 1);
    chk("R5 chan_en cleared", 32'(chan_en), 0);

    // R3: per_req has no effect on an auto descriptor
    c = mk_ctrl(2'd2, 10'd3, 2'd0, 2'd0, 2'd0, 4'd0);
    load(1'b0, 32'h10, 32'h80, c);
    pulse(0);
    wr_cnt = 0;
    pulse(4); repeat (8) @(negedge clk);
    chk("R3 per_req ignored writes", 32'(wr_cnt), 0);
    chk("R3 per_req ignored enable", 32'(chan_en), 1);
    pulse(5); wait_done(40); @(negedge clk);
    chk("R3 sw_req completes", 32'(wr_cnt), 4);

    // R7: alternate descriptor selected
    fill();
    load(1'b1, 32'h10, 32'hC0, mk_ctrl(2'd1, 10'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    pulse(2); pulse(0);
    pulse(4); wait_done(20); @(negedge clk);
    chk("R7 alt_active", 32'(alt_active), 1);
    chk("R7 alternate dst written", 32'(mem[8'hC0]), 32'(pat('h10)));

    // R11: enable with invalid active descriptor
    pulse(3);
    wr_cnt = 0;
    pulse(0); @(negedge clk);
    chk("R11 chan_en dropped", 32'(chan_en), 0);
    pulse(4); repeat (4) @(negedge clk);
    chk("R11 no transfer", 32'(wr_cnt), 0);

    // R8 R10: ping-pong primary then basic alternate
    load(1'b0, 32'h10, 32'h80, mk_ctrl(2'd3, 10'd1, 2'd0, 2'd0, 2'd0, 4'd15));
    load(1'b1, 32'h20, 32'h90, mk_ctrl(2'd1, 10'd2, 2'd0, 2'd0, 2'd0, 4'd15));
    pulse(3); pulse(0);
    wr_cnt = 0; done_cnt = 0;
    pulse(4); wait_done(20); @(negedge clk);
    chk("R8 writes of primary", 32'(wr_cnt), 2);
    chk("R8 alt_active toggled", 32'(alt_active), 1);
    chk("R8 chan_en kept", 32'(chan_en), 1);
    pulse(4); wait_done(20); @(negedge clk);
    chk("R10 writes total", 32'(wr_cnt), 5);
    chk("R10 chan_en cleared", 32'(chan_en), 0);
    chk("R10 done pulses", 32'(done_cnt), 2);

    // R9: ping-pong halts on invalid partner
    load(1'b0, 32'h10, 32'h80, mk_ctrl(2'd3, 10'd0, 2'd0, 2'd0, 2'd0, 4'd0));
    pulse(3); pulse(0);
    done_cnt = 0;
    pulse(4); wait_done(20); @(negedge clk);
    chk("R9 done pulsed", 32'(done_cnt), 1);
    chk("R9 chan_en halted", 32'(chan_en), 0);
    chk("R9 alt_active toggled", 32'(alt_active), 1);

    // R13: maximum count, fixed pointers
    fill();
    load(1'b0, 32'h10, 32'hF0, mk_ctrl(2'd2, 10'd1023, 2'd0, 2'd3, 2'd3, 4'd0));
    pulse(3); pulse(0);
    wr_cnt = 0;
    pulse(5); wait_done(2200); @(negedge clk);
    chk("R13 element count", 32'(wr_cnt), 1024);
    chk("R13 fixed dst data", 32'(mem[8'hF0]), 32'(pat('h10)));
    chk("R13 chan_en cleared", 32'(chan_en), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule